// File: doc/BRIEF.md
# Converter Sequencer Control Interface

This block is the digital controller for a 10-bit successive-approximation analog-to-digital converter with twelve inputs. Software writes a small set of registers to choose a channel, enable the converter, pick the conversion clock and the reference, and request a conversion. The block then drives a start pulse, the channel number and a conversion clock enable toward the analog macro. When the macro reports completion, the block captures the 10-bit result, returns to idle and raises an interrupt flag.

The result is returned in two pieces: the upper eight bits in a dedicated result byte and the two least significant bits in the top of the control/status byte. The request bit clears itself at the moment the idle status returns to 1, so a polling loop can wait either on that bit or on the status bit. Twelve active-low select bits, one per pin, place pins in analog mode.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control/status byte reads 8'h20 (only the idle status bit 5 set), the result byte reads 0, all twelve pin selects read 1, `irq`, `conv_start` and `conv_clk_en` are 0.
- R2: A control write (address 0) with enable (bit 0) and request (bit 1) both 1, while idle, makes `conv_start` high for exactly one cycle on the next cycle, with the held channel on `conv_chan`; status bit 5 reads 0 from that cycle until completion.
- R3: A request written while the enable bit in the same write is 0 is dropped: bit 1 reads 0 and no conversion starts.
- R4: In the cycle after `conv_done` is seen during a conversion, status bit 5 reads 1 and request bit 1 reads 0 together.
- R5: On completion, result bits 9:2 appear on `result_hi` and bits 1:0 appear on control/status bits 7:6.
- R6: Flag bit 4 is set on completion and stays 1 until a control write with bit 4 at 1 clears it.
- R7: `irq` is 1 exactly when flag bit 4 is 1 and `adc_ie` is 1.
- R8: A channel write (address 1, bits 3:0) during a conversion leaves `conv_chan` unchanged; the new code is used by the next conversion.
- R9: A channel write with a code of 12 to 15 is ignored; the previously held channel stays in use.
- R10: `conv_clk_en` is 0 while idle; during a conversion it pulses every other cycle when clock select (bit 2) is 0, and follows `pwm_tick` when it is 1.
- R11: Address 2 bits 7:0 write the selects of pins 7 to 0 and address 3 bits 3:0 those of pins 11 to 8, onto `ana_sel_n`; no other write changes them.
- R12: `conv_ref_sel` follows the reference select (control bit 3) of the last control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 channel, 2 pins 7:0, 3 pins 11:8 |
| wr_data | input | 8 | Write data |
| adc_ie | input | 1 | Converter interrupt enable from the interrupt controller |
| pwm_tick | input | 1 | Prescaled clock enable from the PWM divider |
| conv_done | input | 1 | Completion pulse from the analog macro |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| ctrl_rd | output | 8 | Control/status: 0 enable, 1 request, 2 clock select, 3 reference, 4 flag, 5 idle, 7:6 result low bits |
| result_hi | output | 8 | Result bits 9:2 |
| ana_sel_n | output | 12 | Active-low analog-mode select per pin |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-cycle start pulse to the macro |
| conv_chan | output | 4 | Channel of the current or last conversion |
| conv_clk_en | output | 1 | Conversion clock enable |
| conv_ref_sel | output | 1 | Reference select to the macro |

## Verification
A stuck sequencer state shows at once in status bit 5: it either never falls after a request or never rises after `conv_done`, and the bench times out on both waits within tens of cycles. A wrong held-channel register appears at the next start as an unexpected `conv_chan`, which the converter model turns into a result that the scoreboard rejects. A flag or request bit left in the wrong state is visible in the control/status byte on the cycle following completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int DATA_W  = 8;
    localparam int RES_W   = 10;
    localparam int CHAN_W  = 4;
    localparam int NUM_CH  = 12;
    localparam int ADDR_W  = 2;
    localparam int PIN_LO_W = 8;
    localparam int PIN_HI_W = NUM_CH - PIN_LO_W;
    localparam int RES_HI_W = RES_W - 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_CHAN  = 2'd1,
        A_PINLO = 2'd2,
        A_PINHI = 2'd3
    } reg_addr_e;

    localparam int B_EN   = 0;
    localparam int B_REQ  = 1;
    localparam int B_CSEL = 2;
    localparam int B_REF  = 3;
    localparam int B_FLAG = 4;
    localparam int B_IDLE = 5;

    typedef struct packed {
        logic ref_sel;
        logic clk_sel;
        logic req;
        logic en;
    } cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    function automatic logic chan_valid(input logic [CHAN_W-1:0] c);
        return int'(c) < NUM_CH;
    endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               running,
    input  logic               done_pulse,
    output cfg_t               cfg,
    output logic [CHAN_W-1:0]  pend_chan,
    output logic [NUM_CH-1:0]  ana_sel_n
);
    logic wr_ctrl, wr_chan;
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_chan = wr_en && (wr_addr == A_CHAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.en      <= wr_data[B_EN];
                cfg.clk_sel <= wr_data[B_CSEL];
                cfg.ref_sel <= wr_data[B_REF];
            end
            if (done_pulse)
                cfg.req <= 1'b0;
            else if (wr_ctrl && !running)
                cfg.req <= wr_data[B_REQ] & wr_data[B_EN];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_chan <= '0;
        else if (wr_chan && chan_valid(wr_data[CHAN_W-1:0]))
            pend_chan <= wr_data[CHAN_W-1:0];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_pin
            localparam int ADR = (gi < PIN_LO_W) ? int'(A_PINLO) : int'(A_PINHI);
            localparam int BIT = (gi < PIN_LO_W) ? gi : gi - PIN_LO_W;
            always_ff @(posedge clk) begin
                if (rst)
                    ana_sel_n[gi] <= 1'b1;
                else if (wr_en && (int'(wr_addr) == ADR))
                    ana_sel_n[gi] <= wr_data[BIT];
            end
        end
    endgenerate

    logic unused_wr_bits;
    assign unused_wr_bits = &{wr_data[DATA_W-1:B_FLAG]};
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cfg_t               cfg,
    input  logic [CHAN_W-1:0]  pend_chan,
    input  logic               flag_clr,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_result,
    output logic               running,
    output logic               done_pulse,
    output logic               conv_start,
    output logic [CHAN_W-1:0]  act_chan,
    output logic [RES_W-1:0]   result,
    output logic               flag
);
    seq_state_e state;
    logic       go;

    assign running    = (state == ST_RUN);
    assign go         = !running && cfg.en && cfg.req;
    assign done_pulse = running && conv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            conv_start <= 1'b0;
            act_chan   <= '0;
            result     <= '0;
        end else begin
            conv_start <= go;
            if (go) begin
                state    <= ST_RUN;
                act_chan <= pend_chan;
            end else if (done_pulse) begin
                state  <= ST_IDLE;
                result <= conv_result;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (done_pulse)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/adc_seq_clkgen.sv
module adc_seq_clkgen (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic clk_sel,
    input  logic pwm_tick,
    output logic conv_clk_en
);
    logic half;

    always_ff @(posedge clk) begin
        if (rst)
            half <= 1'b0;
        else
            half <= !half;
    end

    assign conv_clk_en = running && (clk_sel ? pwm_tick : half);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               adc_ie,
    input  logic               pwm_tick,
    input  logic               conv_done,
    input  logic [9:0]         conv_result,
    output logic [7:0]         ctrl_rd,
    output logic [7:0]         result_hi,
    output logic [11:0]        ana_sel_n,
    output logic               irq,
    output logic               conv_start,
    output logic [3:0]         conv_chan,
    output logic               conv_clk_en,
    output logic               conv_ref_sel
);
    cfg_t              cfg;
    logic [CHAN_W-1:0] pend_chan;
    logic              running, done_pulse, flag, flag_clr;
    logic [RES_W-1:0]  result;

    assign flag_clr = wr_en && (wr_addr == A_CTRL) && wr_data[B_FLAG];

    adc_seq_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .running(running), .done_pulse(done_pulse),
        .cfg(cfg), .pend_chan(pend_chan), .ana_sel_n(ana_sel_n)
    );

    adc_seq_core u_core (
        .clk(clk), .rst(rst), .cfg(cfg), .pend_chan(pend_chan), .flag_clr(flag_clr),
        .conv_done(conv_done), .conv_result(conv_result),
        .running(running), .done_pulse(done_pulse), .conv_start(conv_start),
        .act_chan(conv_chan), .result(result), .flag(flag)
    );

    adc_seq_clkgen u_clk (
        .clk(clk), .rst(rst), .running(running), .clk_sel(cfg.clk_sel),
        .pwm_tick(pwm_tick), .conv_clk_en(conv_clk_en)
    );

    assign ctrl_rd      = {result[1:0], !running, flag, cfg.ref_sel, cfg.clk_sel, cfg.req, cfg.en};
    assign result_hi    = result[RES_W-1:2];
    assign irq          = flag && adc_ie;
    assign conv_ref_sel = cfg.ref_sel;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic        adc_ie,
    input logic [7:0]  ctrl_rd,
    input logic [11:0] ana_sel_n,
    input logic        irq,
    input logic        conv_start,
    input logic [3:0]  conv_chan,
    input logic        conv_clk_en
);
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !ctrl_rd[5]);

    assert_req_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rd[5]) |-> !ctrl_rd[1]);

    assert_flag_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rd[5]) |-> ctrl_rd[4]);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[4] && !(wr_en && wr_addr == 2'd0 && wr_data[4])) |=> ctrl_rd[4]);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !adc_ie |-> !irq);

    assert_chan_held_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(conv_chan) |-> conv_start);

    assert_no_idle_clk_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd[5] |-> !conv_clk_en);

    assert_half_rate_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_rd[2] && conv_clk_en) |=> (ctrl_rd[2] || !conv_clk_en));

    assert_pins_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ana_sel_n));
endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .adc_ie(adc_ie), .ctrl_rd(ctrl_rd), .ana_sel_n(ana_sel_n), .irq(irq),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_clk_en(conv_clk_en)
);

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        adc_ie = 1'b0;
    logic        pwm_tick = 1'b0;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_result = '0;
    logic [7:0]  ctrl_rd, result_hi;
    logic [11:0] ana_sel_n;
    logic        irq, conv_start, conv_clk_en, conv_ref_sel;
    logic [3:0]  conv_chan;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    logic [3:0] model_chan;
    int busy_cnt, tick_cnt;
    bit dbl_tick, idle_tick, prev_tick, prev_idle;

    always #4 clk = !clk;

    adc_seq_top dut_i (.*);

    function automatic logic [9:0] model_fn(input int c);
        return 10'((c * 83 + 301) & 10'h3FF);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle_fall();
        for (int i = 0; i < 5 && ctrl_rd[5]; i++) @(negedge clk);
    endtask

    task automatic wait_idle_rise();
        for (int i = 0; i < 40 && !ctrl_rd[5]; i++) @(negedge clk);
    endtask

    // driver: push expected channel, start, wait for completion
    task automatic run_conv(input int exp_ch, input logic [7:0] ctl);
        exp_q.push_back(exp_ch);
        wr(2'd0, ctl | 8'h03);
        wait_idle_fall();
        wait_idle_rise();
    endtask

    // converter model: fixed latency, result derived from channel
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                model_chan = conv_chan;
                repeat (LAT) @(negedge clk);
                conv_result = model_fn(int'(model_chan));
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    // monitor: scoreboard compare at each completion, clock tick counting
    always @(negedge clk) begin
        if (!rst) begin
            if (!prev_idle && ctrl_rd[5]) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected completion", 1, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check("R8 channel used", int'(model_chan), e);
                    check("R5 split result", int'({result_hi, ctrl_rd[7:6]}), int'(model_fn(e)));
                end
            end
            prev_idle = ctrl_rd[5];
            if (conv_start) begin busy_cnt = 0; tick_cnt = 0; dbl_tick = 0; prev_tick = 0; end
            if (!ctrl_rd[5]) begin
                busy_cnt++;
                if (conv_clk_en) begin
                    tick_cnt++;
                    if (prev_tick) dbl_tick = 1;
                end
                prev_tick = conv_clk_en;
            end else begin
                if (conv_clk_en) idle_tick = 1;
                prev_tick = 0;
            end
        end else begin
            prev_idle = 1'b1;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl", int'(ctrl_rd), 32'h20);
        check("R1 result", int'(result_hi), 0);
        check("R1 pins", int'(ana_sel_n), 32'hFFF);
        check("R1 outs", int'({irq, conv_start, conv_clk_en}), 0);

        // R3 request without enable dropped
        wr(2'd0, 8'h02);
        check("R3 req bit", int'(ctrl_rd[1]), 0);
        repeat (3) @(negedge clk);
        check("R3 still idle", int'(ctrl_rd[5]), 1);

        // R2 normal start on channel 5
        wr(2'd1, 8'd5);
        exp_q.push_back(5);
        wr(2'd0, 8'h03);
        check("R2 req set", int'(ctrl_rd[1]), 1);
        @(negedge clk);
        check("R2 start pulse", int'(conv_start), 1);
        check("R2 busy", int'(ctrl_rd[5]), 0);
        check("R2 channel", int'(conv_chan), 5);
        @(negedge clk);
        check("R2 pulse one cycle", int'(conv_start), 0);
        wait_idle_rise();
        check("R4 idle back", int'(ctrl_rd[5]), 1);
        check("R4 req cleared", int'(ctrl_rd[1]), 0);
        check("R6 flag set", int'(ctrl_rd[4]), 1);
        check("R10 half rate no double", int'(dbl_tick), 0);
        check("R10 half rate count", int'(tick_cnt >= 3 && tick_cnt <= 4), 1);
        check("R10 busy length", busy_cnt, LAT + 1);

        // R7 interrupt masking
        check("R7 masked", int'(irq), 0);
        @(negedge clk); adc_ie = 1'b1; #1;
        check("R7 raised", int'(irq), 1);
        repeat (4) @(negedge clk);
        check("R6 flag sticky", int'(ctrl_rd[4]), 1);
        wr(2'd0, 8'h11);
        check("R6 flag cleared", int'(ctrl_rd[4]), 0);
        check("R7 dropped", int'(irq), 0);

        // R8 channel write held during a conversion
        wr(2'd1, 8'd3);
        exp_q.push_back(3);
        wr(2'd0, 8'h03);
        @(negedge clk);
        wr(2'd1, 8'd9);
        check("R8 chan held", int'(conv_chan), 3);
        wait_idle_rise();
        run_conv(9, 8'h00);
        check("R8 next start uses new", int'(conv_chan), 9);

        // R9 invalid channel ignored
        wr(2'd1, 8'd13);
        run_conv(9, 8'h00);
        check("R9 chan unchanged", int'(conv_chan), 9);
        wr(2'd1, 8'd11);
        run_conv(11, 8'h00);

        // R10 prescaled clock source
        pwm_tick = 1'b0;
        run_conv(11, 8'h04);
        check("R10 pwm low no ticks", tick_cnt, 0);
        pwm_tick = 1'b1;
        run_conv(11, 8'h04);
        check("R10 pwm high every cycle", tick_cnt, busy_cnt);
        pwm_tick = 1'b0;
        check("R10 no idle ticks", int'(idle_tick), 0);

        // R12 reference select
        wr(2'd0, 8'h09);
        check("R12 ref on", int'(conv_ref_sel), 1);
        wr(2'd0, 8'h01);
        check("R12 ref off", int'(conv_ref_sel), 0);

        // R11 pin selects
        wr(2'd2, 8'hA5);
        check("R11 low pins", int'(ana_sel_n), 32'hFA5);
        wr(2'd3, 8'hF3);
        check("R11 high pins", int'(ana_sel_n), 32'h3A5);
        wr(2'd1, 8'd2);
        check("R11 other write", int'(ana_sel_n), 32'h3A5);

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule